// File: doc/BRIEF.md
# Codec Power-Down Sequencer

This block is the power state machine of a PCM voice codec. Reset leaves the device powered down, with the serial data output and the analog output in high impedance. One input pin does two jobs: it can carry the receive master clock or act as a power-down control. A classifier watches that pin over fixed windows of system clocks and sorts it into three states: static low, static high or clocked. A static high forces power-down. A static low or a running clock allows the device to power up. When the pin is static, the receive side runs from the transmit master clock.

With the pin allowing it, the first rising edge of either the transmit or the receive frame sync powers the device up. An inactivity timer counts a 1 µs tick and is reloaded by every frame-sync rising edge. If it runs out, the device powers down again. After each power-up the transmit data output is still not allowed to drive. Permission is granted only from the second transmit frame sync onward.

All inputs arrive already synchronized to the system clock. The frame syncs come in as single-cycle rising-edge pulses. The outputs are the power-up flag, the data-output permission and the receive-clock select.

Top module: `codec_pwr_seq`

## Requirements
- R1: During and right after reset, `pwr_up` is 0, `tx_out_permit` is 0 and `rx_clk_from_tx` is 1. The pin class starts as static high, which means powered down.
- R2: The pin is classified at the end of each window of `WIN_CYCLES` system clocks. Any level change seen inside the window gives "clocked". Otherwise the class follows the steady level: 0 gives "static low", 1 gives "static high".
- R3: `rx_clk_from_tx` is 1 while the pin class is static low or static high, and 0 while it is clocked.
- R4: While powered down and the class is not static high, a pulse on `tx_sync_rise` or `rx_sync_rise` sets `pwr_up` at the next clock edge. With no sync pulse the block stays powered down.
- R5: While the class is static high, sync pulses are ignored and `pwr_up` stays 0.
- R6: Once the class becomes static high, `pwr_up` is 0 from the next clock edge onward.
- R7: A power-up or any later sync pulse starts a count of `TIMEOUT_TICKS` ticks (default 1000). If that many `us_tick` pulses arrive with no sync pulse in between, `pwr_up` falls at the edge that takes the last tick.
- R8: Every sync pulse on either direction reloads the inactivity count to `TIMEOUT_TICKS`. A forced power-down clears the count.
- R9: `tx_out_permit` is 1 only while powered up and only after `SYNCS_TO_ENABLE` transmit sync pulses (default 2) since power-up. A transmit pulse that causes the power-up counts as the first. Receive pulses do not count.
- R10: Any power-down clears `tx_out_permit` and the transmit-pulse count, so the next power-up needs the full number of transmit pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_pin_lvl | input | 1 | Synchronized level of the shared receive-clock / power-down pin |
| tx_sync_rise | input | 1 | Single-cycle pulse on a transmit frame-sync rising edge |
| rx_sync_rise | input | 1 | Single-cycle pulse on a receive frame-sync rising edge |
| us_tick | input | 1 | Single-cycle pulse once per microsecond |
| pwr_up | output | 1 | Device powered up; analog output may leave high impedance |
| tx_out_permit | output | 1 | Transmit data output may be enabled |
| rx_clk_from_tx | output | 1 | Receive timing taken from the transmit master clock |

## Verification
The hardest situation to reach is the exact edge of the inactivity timeout when a reload arrives partway through. A receive sync landing in the middle of a countdown must restart it, and the power-down must then come exactly `TIMEOUT_TICKS` ticks after that pulse, not after the original power-up. The bench issues ticks one pulse at a time. It checks that the device is still up one tick before the deadline and down on the tick that reaches it, both for a plain countdown and for one restarted by a receive pulse. Pin-class changes need whole classification windows, so every table step holds its pin pattern for more than two windows before the sync pulses are applied.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
   typedef enum logic [1:0] {
      PIN_LOW     = 2'd0,
      PIN_HIGH    = 2'd1,
      PIN_CLOCKED = 2'd2
   } pin_class_t;
endpackage

// File: rtl/cpd_pin_classifier.sv
module cpd_pin_classifier
   import codec_pwr_pkg::*;
#(
   parameter int WIN_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_lvl,
   output pin_class_t pin_class
);
   localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

   logic [CW-1:0] win_cnt;
   logic          prev_lvl;
   logic          primed;
   logic          edge_seen;
   logic          edge_now;
   logic          win_last;

   assign edge_now = primed && (pin_lvl != prev_lvl);
   assign win_last = (win_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt   <= '0;
         prev_lvl  <= 1'b0;
         primed    <= 1'b0;
         edge_seen <= 1'b0;
         pin_class <= PIN_HIGH;
      end else begin
         prev_lvl <= pin_lvl;
         primed   <= 1'b1;
         if (win_last) begin
            win_cnt   <= '0;
            edge_seen <= 1'b0;
            if (edge_seen || edge_now)
               pin_class <= PIN_CLOCKED;
            else
               pin_class <= pin_lvl ? PIN_HIGH : PIN_LOW;
         end else begin
            win_cnt <= win_cnt + 1'b1;
            if (edge_now)
               edge_seen <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cpd_idle_timer.sv
module cpd_idle_timer #(
   parameter int TIMEOUT_TICKS = 1000
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   clear,
   input  logic                                   reload,
   input  logic                                   tick,
   output logic                                   expire,
   output logic [$clog2(TIMEOUT_TICKS+1)-1:0]     count
);
   localparam int TW = $clog2(TIMEOUT_TICKS + 1);
   localparam logic [TW-1:0] LOAD = TW'(TIMEOUT_TICKS);
   localparam logic [TW-1:0] ONE  = TW'(1);

   assign expire = tick && !reload && !clear && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clear)
         count <= '0;
      else if (reload)
         count <= LOAD;
      else if (tick && (count != '0))
         count <= count - 1'b1;
   end
endmodule

// File: rtl/cpd_power_fsm.sv
module cpd_power_fsm #(
   parameter int SYNCS_TO_ENABLE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_rise,
   input  logic rx_rise,
   input  logic force_down,
   input  logic idle_expire,
   output logic pwr_up,
   output logic out_permit
);
   localparam int CNTW = $clog2(SYNCS_TO_ENABLE + 1);
   localparam logic [CNTW-1:0] TARGET = CNTW'(SYNCS_TO_ENABLE);

   logic [CNTW-1:0] tx_cnt;

   assign out_permit = pwr_up && (tx_cnt == TARGET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_up <= 1'b0;
         tx_cnt <= '0;
      end else if (force_down || (pwr_up && idle_expire)) begin
         pwr_up <= 1'b0;
         tx_cnt <= '0;
      end else if (!pwr_up) begin
         if (tx_rise || rx_rise) begin
            pwr_up <= 1'b1;
            tx_cnt <= CNTW'(tx_rise);
         end
      end else if (tx_rise && (tx_cnt != TARGET)) begin
         tx_cnt <= tx_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
   import codec_pwr_pkg::*;
#(
   parameter int WIN_CYCLES      = 64,
   parameter int TIMEOUT_TICKS   = 1000,
   parameter int SYNCS_TO_ENABLE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_pin_lvl,
   input  logic tx_sync_rise,
   input  logic rx_sync_rise,
   input  logic us_tick,
   output logic pwr_up,
   output logic tx_out_permit,
   output logic rx_clk_from_tx
);
   localparam int TW = $clog2(TIMEOUT_TICKS + 1);

   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("WIN_CYCLES must be at least 2");
      end
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("TIMEOUT_TICKS must be at least 2");
      end
      if (SYNCS_TO_ENABLE < 1) begin : g_bad_syncs
         $error("SYNCS_TO_ENABLE must be at least 1");
      end
   endgenerate

   pin_class_t    pin_class;
   logic          force_down;
   logic          any_sync;
   logic          idle_expire;
   logic [TW-1:0] idle_count;

   assign force_down     = (pin_class == PIN_HIGH);
   assign any_sync       = tx_sync_rise || rx_sync_rise;
   assign rx_clk_from_tx = (pin_class != PIN_CLOCKED);

   cpd_pin_classifier #(.WIN_CYCLES(WIN_CYCLES)) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_lvl   (pd_pin_lvl),
      .pin_class (pin_class)
   );

   cpd_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (force_down),
      .reload (any_sync),
      .tick   (us_tick),
      .expire (idle_expire),
      .count  (idle_count)
   );

   cpd_power_fsm #(.SYNCS_TO_ENABLE(SYNCS_TO_ENABLE)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_rise     (tx_sync_rise),
      .rx_rise     (rx_sync_rise),
      .force_down  (force_down),
      .idle_expire (idle_expire),
      .pwr_up      (pwr_up),
      .out_permit  (tx_out_permit)
   );
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk
   import codec_pwr_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 1000
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 tx_sync_rise,
   input logic                                 rx_sync_rise,
   input logic                                 pwr_up,
   input logic                                 tx_out_permit,
   input pin_class_t                           pin_class,
   input logic [$clog2(TIMEOUT_TICKS+1)-1:0]   idle_count
);
   localparam int TW = $clog2(TIMEOUT_TICKS + 1);

   AST_UP_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_up && (tx_sync_rise || rx_sync_rise) && pin_class != PIN_HIGH) |=> pwr_up); // R4

   AST_STAY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_up && !tx_sync_rise && !rx_sync_rise) |=> !pwr_up); // R4

   AST_HIGH_BLOCKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_up && pin_class == PIN_HIGH) |=> !pwr_up); // R5

   AST_HIGH_FORCES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_class == PIN_HIGH) |=> !pwr_up); // R6

   AST_UP_HAS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_up |-> (idle_count != '0)); // R7

   AST_SYNC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_sync_rise || rx_sync_rise) && pin_class != PIN_HIGH)
      |=> (idle_count == TW'(TIMEOUT_TICKS))); // R8

   AST_PERMIT_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_permit |-> pwr_up); // R9

   AST_PERMIT_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_out_permit) |-> $past(tx_sync_rise)); // R9

   AST_DOWN_CLEARS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_up) |-> !tx_out_permit); // R10
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_sync_rise  (tx_sync_rise),
   .rx_sync_rise  (rx_sync_rise),
   .pwr_up        (pwr_up),
   .tx_out_permit (tx_out_permit),
   .pin_class     (pin_class),
   .idle_count    (idle_count)
);

// File: tb/codec_pwr_seq_test.sv
module codec_pwr_seq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_pin_lvl = 1'b0;
   logic tx_sync_rise = 1'b0;
   logic rx_sync_rise = 1'b0;
   logic us_tick = 1'b0;
   logic pwr_up, tx_out_permit, rx_clk_from_tx;

   logic [1:0] pin_mode = 2'd0;   // 0 static low, 1 static high, 2 clocked
   logic [1:0] div = 2'd0;
   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   codec_pwr_seq uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .pd_pin_lvl     (pd_pin_lvl),
      .tx_sync_rise   (tx_sync_rise),
      .rx_sync_rise   (rx_sync_rise),
      .us_tick        (us_tick),
      .pwr_up         (pwr_up),
      .tx_out_permit  (tx_out_permit),
      .rx_clk_from_tx (rx_clk_from_tx)
   );

   always @(negedge clk) begin
      div <= div + 2'd1;
      if (pin_mode == 2'd2) begin
         if (div == 2'd0) pd_pin_lvl <= ~pd_pin_lvl;
      end else begin
         pd_pin_lvl <= (pin_mode == 2'd1);
      end
   end

   // Vector: [7:6] pin mode, [5] tx pulse, [4] rx pulse,
   //         [2] expected pwr_up, [1] expected permit, [0] expected rx select
   localparam logic [7:0] VEC [0:7] = '{
      8'h01,  // low, no sync: stays down (R2 R3 R4)
      8'h15,  // low, rx sync: up, no permit (R4 R9)
      8'h25,  // low, first tx sync: no permit yet (R9)
      8'h27,  // low, second tx sync: permit (R9)
      8'h41,  // high: forced down (R2 R6 R10)
      8'h71,  // high, syncs ignored (R5)
      8'hA4,  // clocked, tx powers up, count restarted (R3 R4 R10)
      8'hA6   // clocked, second tx: permit (R9)
   };

   function automatic string step_tag(int i);
      case (i)
         0: return "R2/R3/R4 static low idle";
         1: return "R4/R9 rx power-up";
         2: return "R9 first tx";
         3: return "R9 second tx";
         4: return "R6/R10 pin high";
         5: return "R5 sync while high";
         6: return "R3/R4/R10 clocked pin";
         default: return "R9 clocked second tx";
      endcase
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic pulse_tx();
      @(negedge clk) tx_sync_rise = 1'b1;
      @(negedge clk) tx_sync_rise = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_rx();
      @(negedge clk) rx_sync_rise = 1'b1;
      @(negedge clk) rx_sync_rise = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) us_tick = 1'b1;
         @(negedge clk) us_tick = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "pwr_up in reset", pwr_up, 1'b0);
      check("R1", "permit in reset", tx_out_permit, 1'b0);
      check("R1", "rx select in reset", rx_clk_from_tx, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "pwr_up after reset", pwr_up, 1'b0);
      // R5: class still high before first window ends
      pulse_tx();
      check("R5", "sync before first window", pwr_up, 1'b0);

      for (int i = 0; i < 8; i++) begin
         pin_mode = VEC[i][7:6];
         repeat (140) @(negedge clk);
         if (VEC[i][5]) pulse_tx();
         if (VEC[i][4]) pulse_rx();
         check(step_tag(i), "pwr_up", pwr_up, VEC[i][2]);
         check(step_tag(i), "tx_out_permit", tx_out_permit, VEC[i][1]);
         check(step_tag(i), "rx_clk_from_tx", rx_clk_from_tx, VEC[i][0]);
      end

      // R7: plain countdown from the last sync (device up, permitted)
      pin_mode = 2'd0;
      repeat (140) @(negedge clk);
      check("R3", "rx select back to static", rx_clk_from_tx, 1'b1);
      ticks(999);
      check("R7", "up one tick before timeout", pwr_up, 1'b1);
      check("R7", "permit before timeout", tx_out_permit, 1'b1);
      ticks(1);
      check("R7", "down at timeout", pwr_up, 1'b0);
      check("R10", "permit cleared by timeout", tx_out_permit, 1'b0);

      // R8: reload by a receive sync in mid-countdown
      pulse_tx();
      check("R4", "tx powers up again", pwr_up, 1'b1);
      check("R10", "count restarted after timeout", tx_out_permit, 1'b0);
      ticks(600);
      pulse_rx();
      ticks(600);
      check("R8", "up past original deadline", pwr_up, 1'b1);
      check("R9", "rx sync does not count", tx_out_permit, 1'b0);
      ticks(399);
      check("R8", "up one tick before reloaded deadline", pwr_up, 1'b1);
      ticks(1);
      check("R8", "down at reloaded deadline", pwr_up, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule